// File: doc/BRIEF.md
# Voltage Channel Window Alarm

This block watches the 8-bit conversion results of a multichannel voltage monitor. Each result is an unsigned code in which one step stands for 8 mV, so the full input span runs from 0 V to 2.040 V. Results arrive one at a time with the index of the channel they belong to. The block compares each result against a lower and an upper bound held for that channel. When the result falls outside that window, a sticky alarm bit for the channel is set. Every bound keeps only its upper six bits, so the window edges move in steps of four codes.

Software reaches the block through a small register port. The port writes the bounds, reads them back, and reads the alarm bits; reading an alarm byte clears it. The port also reports which channels pass through an internal divide-by-two. Channel 0 always does. On the extended variant, channels 9 and 10 do as well. The sample input is a valid/ready stream with one rule for back-pressure: the block holds `smp_ready` low only while reset is asserted, and keeps it high from the first clock after reset is released. A sample is taken on every rising edge where `smp_valid` and `smp_ready` are both high, so a source may hold `smp_valid` high and present a new sample on every cycle.

Top module: `vmon_window_alarm`

## Requirements
- R1: `smp_ready` is low while `rst_n` is low, goes high at the first rising clock edge after reset is released, and stays high from then on. A sample is taken at each edge where `smp_valid` and `smp_ready` are both high.
- R2: A sample taken for channel c whose code is strictly smaller than that channel's lower bound sets alarm bit c at that same edge. A code equal to the lower bound sets nothing.
- R3: A sample taken for channel c whose code is strictly greater than that channel's upper bound sets alarm bit c at that same edge. A code equal to the upper bound sets nothing.
- R4: A write of byte d stores d with bits 1:0 forced to zero. The lower bound of channel c sits at address c and the upper bound at address 16+c. Bits 1:0 of a bound always read as zero.
- R5: After reset every lower bound reads 0x00, every upper bound reads 0xFC, and every alarm bit is clear.
- R6: An alarm bit stays set until software reads the status byte that holds it.
- R7: Alarm bits 7:0 read at address 0x20 and bits 15:8 at address 0x21, with unused bits reading as zero. Reading a status byte returns its bits and clears them at that edge. When a sample sets a bit in the same cycle as the clearing read, the bit ends up set.
- R8: A sample whose channel index is NUM_CH or larger changes no alarm bit.
- R9: Address 0x28 reads divider flags 7:0 and address 0x29 reads flags 15:8. Flag 0 is always 1. Flags 9 and 10 are 1 when EXTENDED is set. All other flags are 0.
- R10: A read presents its data on `reg_rdata`, with `reg_rvalid` high, right after the edge that took `reg_rd`. `reg_rvalid` is low after any edge with no read. An unmapped address reads as 0x00, and writes to any address other than a bound have no effect.
- R11: `alarm_o` shows the current alarm bits of all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample present on the stream |
| smp_ready | output | 1 | Block accepts a sample this cycle |
| smp_chan | input | CH_W (4) | Channel index of the sample |
| smp_code | input | 8 | Conversion code, 8 mV per step |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (6) | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_rvalid | output | 1 | Read data valid |
| alarm_o | output | NUM_CH (11) | Live alarm bits |

## Verification
Two things can act on the same alarm bit in one cycle: the clear-on-read of a status byte and the setting of that bit by an out-of-window sample. The bench drives both together on purpose. It first sets a bit, then reads its status byte in the same cycle that another violating sample arrives for that channel. Random traffic also mixes status reads with samples, so the two meet many more times. The bench expects two things: the read returns the bit as it stood before the edge, and the bit is still set afterwards.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

  typedef logic [7:0] code_t;

  // Bounds keep only the upper six bits of a code.
  localparam int    KEEP_W   = 6;
  localparam int    DROP_W   = 8 - KEEP_W;
  localparam code_t LO_RESET = 8'h00;
  localparam code_t HI_RESET = 8'hFC;

  // Register map (byte addresses)
  localparam int LO_BASE  = 0;
  localparam int HI_BASE  = 16;
  localparam int ALM_BASE = 32;
  localparam int DIV_BASE = 40;

  // Channel flagged as passing through an internal halving divider
  function automatic logic halved_input(input int idx, input int nch, input bit ext);
    return (idx < nch) && ((idx == 0) || (ext && ((idx == 9) || (idx == 10))));
  endfunction

endpackage

// File: rtl/vmon_limit_bank.sv
module vmon_limit_bank #(
  parameter int NUM_CH = 11,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_CH*8-1:0]   lo_flat,
  output logic [NUM_CH*8-1:0]   hi_flat
);
  import vmon_pkg::*;

  localparam logic [KEEP_W-1:0] LO_RST_K = LO_RESET[7:DROP_W];
  localparam logic [KEEP_W-1:0] HI_RST_K = HI_RESET[7:DROP_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [KEEP_W-1:0] lo_q;
    logic [KEEP_W-1:0] hi_q;
    logic              lo_hit;
    logic              hi_hit;

    assign lo_hit = wr_en && (wr_addr == ADDR_W'(LO_BASE + i));
    assign hi_hit = wr_en && (wr_addr == ADDR_W'(HI_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= LO_RST_K;
        hi_q <= HI_RST_K;
      end else begin
        if (lo_hit) lo_q <= wr_data[7:DROP_W];
        if (hi_hit) hi_q <= wr_data[7:DROP_W];
      end
    end

    assign lo_flat[i*8 +: 8] = {lo_q, {DROP_W{1'b0}}};
    assign hi_flat[i*8 +: 8] = {hi_q, {DROP_W{1'b0}}};
  end

endmodule

// File: rtl/vmon_window_cmp.sv
module vmon_window_cmp #(
  parameter int NUM_CH = 11,
  parameter int CH_W   = 4
) (
  input  logic                  take,
  input  logic [CH_W-1:0]       chan,
  input  logic [7:0]            code,
  input  logic [NUM_CH*8-1:0]   lo_flat,
  input  logic [NUM_CH*8-1:0]   hi_flat,
  output logic [NUM_CH-1:0]     hit
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    logic [7:0] lo;
    logic [7:0] hi;
    logic       sel;
    assign lo  = lo_flat[i*8 +: 8];
    assign hi  = hi_flat[i*8 +: 8];
    assign sel = take && (chan == CH_W'(i));
    assign hit[i] = sel && ((code < lo) || (code > hi));
  end

endmodule

// File: rtl/vmon_alarm_reg.sv
module vmon_alarm_reg #(
  parameter int NUM_CH = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] alarm_q
);

  // Setting wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '0;
    else        alarm_q <= (alarm_q & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/vmon_window_alarm.sv
module vmon_window_alarm #(
  parameter int NUM_CH   = 11,
  parameter bit EXTENDED = 1'b1,
  parameter int CH_W     = 4,
  parameter int ADDR_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [CH_W-1:0]    smp_chan,
  input  logic [7:0]         smp_code,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               reg_rvalid,
  output logic [NUM_CH-1:0]  alarm_o
);
  import vmon_pkg::*;

  localparam int NBYTES = (NUM_CH + 7) / 8;
  localparam int PAD_W  = NBYTES * 8;

  logic                ready_q;
  logic                take;
  logic [NUM_CH*8-1:0] lo_flat;
  logic [NUM_CH*8-1:0] hi_flat;
  logic [NUM_CH-1:0]   hit_vec;
  logic [NUM_CH-1:0]   clr_vec;
  logic [NUM_CH-1:0]   alarm_q;
  logic [PAD_W-1:0]    alarm_pad;
  logic [PAD_W-1:0]    div_pad;
  logic [PAD_W-1:0]    clr_pad;
  logic [7:0]          rd_mux;
  logic [7:0]          rdata_q;
  logic                rvalid_q;

  // Stream acceptance: ready from the first edge after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign smp_ready = ready_q;
  assign take      = smp_valid && ready_q;

  vmon_limit_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .lo_flat (lo_flat),
    .hi_flat (hi_flat)
  );

  vmon_window_cmp #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cmp (
    .take    (take),
    .chan    (smp_chan),
    .code    (smp_code),
    .lo_flat (lo_flat),
    .hi_flat (hi_flat),
    .hit     (hit_vec)
  );

  vmon_alarm_reg #(.NUM_CH(NUM_CH)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (hit_vec),
    .clr_vec (clr_vec),
    .alarm_q (alarm_q)
  );

  // Padded status vectors
  for (genvar b = 0; b < PAD_W; b++) begin : g_pad
    if (b < NUM_CH) begin : g_live
      assign alarm_pad[b] = alarm_q[b];
    end else begin : g_zero
      assign alarm_pad[b] = 1'b0;
    end
    assign div_pad[b] = halved_input(b, NUM_CH, EXTENDED);
  end

  // Clear mask from status-byte reads
  for (genvar k = 0; k < NBYTES; k++) begin : g_clr
    assign clr_pad[k*8 +: 8] =
      {8{reg_rd && (reg_addr == ADDR_W'(ALM_BASE + k))}};
  end
  assign clr_vec = clr_pad[NUM_CH-1:0];

  // Read multiplexer
  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ADDR_W'(LO_BASE + i)) rd_mux = lo_flat[i*8 +: 8];
      if (reg_addr == ADDR_W'(HI_BASE + i)) rd_mux = hi_flat[i*8 +: 8];
    end
    for (int k = 0; k < NBYTES; k++) begin
      if (reg_addr == ADDR_W'(ALM_BASE + k)) rd_mux = alarm_pad[k*8 +: 8];
      if (reg_addr == ADDR_W'(DIV_BASE + k)) rd_mux = div_pad[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
  assign alarm_o    = alarm_q;

endmodule

// File: rtl/vmon_window_alarm_chk.sv
module vmon_window_alarm_chk #(
  parameter int NUM_CH = 11,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [CH_W-1:0]     smp_chan,
  input logic [7:0]          smp_code,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [7:0]          reg_wdata,
  input logic                reg_rvalid,
  input logic [NUM_CH-1:0]   alarm_o,
  input logic [NUM_CH*8-1:0] lo_flat,
  input logic [NUM_CH*8-1:0] hi_flat
);
  import vmon_pkg::*;

  logic              took;
  logic              in_rng;
  logic [NUM_CH-1:0] low_vio;
  logic [NUM_CH-1:0] high_vio;
  logic [NUM_CH-1:0] clr_chk;
  logic [NUM_CH-1:0] keep;

  assign took   = smp_valid && smp_ready;
  assign in_rng = int'(smp_chan) < NUM_CH;

  always_comb begin
    low_vio  = '0;
    high_vio = '0;
    clr_chk  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (took && int'(smp_chan) == i) begin
        low_vio[i]  = smp_code < lo_flat[i*8 +: 8];
        high_vio[i] = smp_code > hi_flat[i*8 +: 8];
      end
      if (reg_rd && int'(reg_addr) == ALM_BASE + i / 8) clr_chk[i] = 1'b1;
    end
  end
  assign keep = alarm_o & ~clr_chk;

  assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> smp_ready);

  assert_low_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_vio != '0) |=> ((alarm_o & $past(low_vio)) == $past(low_vio)));

  assert_high_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (high_vio != '0) |=> ((alarm_o & $past(high_vio)) == $past(high_vio)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lim
    assert_low_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && int'(reg_addr) == LO_BASE + i)
      |=> (lo_flat[i*8 +: 8] == ($past(reg_wdata) & 8'hFC)));
    assert_high_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && int'(reg_addr) == HI_BASE + i)
      |=> (hi_flat[i*8 +: 8] == ($past(reg_wdata) & 8'hFC)));
  end

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((alarm_o & $past(keep)) == $past(keep)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_chk != '0 && !took) |=> ((alarm_o & $past(clr_chk)) == '0));

  assert_foreign_chan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !in_rng && clr_chk == '0) |=> $stable(alarm_o));

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

endmodule

bind vmon_window_alarm vmon_window_alarm_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .smp_chan   (smp_chan),
  .smp_code   (smp_code),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rvalid (reg_rvalid),
  .alarm_o    (alarm_o),
  .lo_flat    (lo_flat),
  .hi_flat    (hi_flat)
);

// File: tb/vmon_window_alarm_tb_top.sv
module vmon_window_alarm_tb_top;

  localparam int NCH = 11;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           smp_valid = 1'b0;
  logic           smp_ready;
  logic [3:0]     smp_chan = '0;
  logic [7:0]     smp_code = '0;
  logic           reg_wr = 1'b0;
  logic           reg_rd = 1'b0;
  logic [5:0]     reg_addr = '0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic           reg_rvalid;
  logic [NCH-1:0] alarm_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [7:0]  lo_m [16];
  logic [7:0]  hi_m [16];
  logic [15:0] alm_m = '0;

  always #2 clk = ~clk;

  vmon_window_alarm dut_i (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_chan(smp_chan), .smp_code(smp_code),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .alarm_o(alarm_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mhit(input logic v, input logic [3:0] ch, input logic [7:0] c);
    logic [15:0] h = '0;
    if (v && int'(ch) < NCH && (c < lo_m[ch] || c > hi_m[ch])) h[ch] = 1'b1;
    return h;
  endfunction

  function automatic logic [7:0] mread(input logic [5:0] a);
    if (a < 6'd16) return (int'(a) < NCH) ? lo_m[a] : 8'h00;
    if (a < 6'd32) return (int'(a) - 16 < NCH) ? hi_m[a - 6'd16] : 8'h00;
    if (a == 6'h20) return alm_m[7:0];
    if (a == 6'h21) return {5'b0, alm_m[10:8]};
    if (a == 6'h28) return 8'h01;
    if (a == 6'h29) return 8'h06;
    return 8'h00;
  endfunction

  // One cycle: inputs driven after a falling edge, results checked 1 ns after the rising edge
  task automatic step(input logic v, input logic [3:0] ch, input logic [7:0] c,
                      input logic wr, input logic rd, input logic [5:0] a,
                      input logic [7:0] wd, input string tag);
    logic [15:0] h;
    logic [15:0] clr;
    logic [7:0]  rexp;
    @(negedge clk);
    smp_valid = v; smp_chan = ch; smp_code = c;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    h    = mhit(v, ch, c);
    rexp = mread(a);
    clr  = '0;
    if (rd && a == 6'h20) clr = 16'h00FF;
    if (rd && a == 6'h21) clr = 16'hFF00;
    @(posedge clk);
    #1;
    alm_m = (alm_m & ~clr) | h;
    if (wr && a < 6'd16 && int'(a) < NCH) lo_m[a] = wd & 8'hFC;
    if (wr && a >= 6'd16 && a < 6'd32 && int'(a) - 16 < NCH) hi_m[a - 6'd16] = wd & 8'hFC;
    chk({"R11 alarm_o after ", tag}, {5'b0, alarm_o}, alm_m);
    chk("R10 rvalid", {15'b0, reg_rvalid}, {15'b0, rd});
    if (rd) chk({"rdata ", tag}, {8'b0, reg_rdata}, {8'b0, rexp});
    smp_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tg;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin lo_m[i] = 8'h00; hi_m[i] = 8'hFC; end

    // R1 / R5: state during and after reset
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", {15'b0, smp_ready}, 16'h0);
    chk("R5 alarm in reset", {5'b0, alarm_o}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 ready after reset", {15'b0, smp_ready}, 16'h1);

    // R5: reset bound values
    step(0, 0, 0, 0, 1, 6'd3,  0, "R5 lo reset");
    step(0, 0, 0, 0, 1, 6'd26, 0, "R5 hi reset");

    // R4: low bits dropped
    step(0, 0, 0, 1, 0, 6'd2,  8'h43, "R4 write lo");
    step(0, 0, 0, 0, 1, 6'd2,  0,     "R4 read lo");
    step(0, 0, 0, 1, 0, 6'd18, 8'hA3, "R4 write hi");
    step(0, 0, 0, 0, 1, 6'd18, 0,     "R4 read hi");

    // R2 / R3 boundaries on channel 2 (lo=0x40, hi=0xA0)
    step(1, 2, 8'h40, 0, 0, 0, 0, "R2 equal low");
    step(1, 2, 8'hA0, 0, 0, 0, 0, "R3 equal high");
    step(1, 2, 8'h3F, 0, 0, 0, 0, "R2 below low");
    step(1, 2, 8'h80, 0, 0, 0, 0, "R6 held");
    step(0, 0, 0, 0, 1, 6'h20, 0, "R7 read clears");
    step(1, 2, 8'hA1, 0, 0, 0, 0, "R3 above high");

    // R7: clear and set in the same cycle
    step(1, 2, 8'h10, 0, 1, 6'h20, 0, "R7 set wins");
    step(0, 0, 0, 0, 1, 6'h20, 0, "R7 second read");

    // R8: foreign channels, R3 on upper byte
    step(1, 4'd11, 8'hFF, 0, 0, 0, 0, "R8 chan 11");
    step(1, 4'd15, 8'h00, 0, 0, 0, 0, "R8 chan 15");
    step(1, 4'd10, 8'hFF, 0, 0, 0, 0, "R3 chan 10");
    step(0, 0, 0, 0, 1, 6'h21, 0, "R7 upper byte");

    // R9 / R10
    step(0, 0, 0, 0, 1, 6'h28, 0, "R9 div low");
    step(0, 0, 0, 0, 1, 6'h29, 0, "R9 div high");
    step(0, 0, 0, 1, 0, 6'h20, 8'hFF, "R10 write status ignored");
    step(0, 0, 0, 0, 1, 6'h30, 0, "R10 unmapped");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic       v  = ($urandom % 10) < 7;
      logic [3:0] ch = 4'($urandom);
      logic [7:0] c  = 8'($urandom);
      logic       wr = ($urandom % 10) == 0;
      logic       rd = ($urandom % 5) == 0;
      logic [5:0] a;
      case ($urandom % 4)
        0: a = 6'h20;
        1: a = 6'h21;
        2: a = 6'(($urandom % 2) * 16 + $urandom % 11);
        default: a = 6'($urandom);
      endcase
      if (v && int'(ch) >= NCH) tg = "R8 random";
      else if (v && c < lo_m[ch]) tg = "R2 random";
      else if (v && c > hi_m[ch]) tg = "R3 random";
      else if (rd && (a == 6'h20 || a == 6'h21)) tg = "R7 random";
      else tg = "R6 random";
      step(v, ch, c, wr, rd, a, 8'($urandom), tg);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule